// File: doc/BRIEF.md
# Versioned Boot Image Selector

This block walks a chain of bootable images in flash and chooses the one to boot. The first image, the factory image, always starts at a fixed address just past the loader area. Any number of further images may follow it, each packed straight after the one before. Every image starts with a small header that holds a version tag and the image length. The block reads the headers one at a time through a word-read port, and the SPI flash controller outside the block serves each read. By default it reports the image whose version tag is the highest unsigned value.

Software or board strapping can force a choice by giving an image index. When that index does not name an image that was found, the block falls back to the factory image and raises a warning flag. A scan starts with a one-cycle `start` pulse. It ends with a one-cycle `done` pulse, and at that point the selected header address, the selected tag and the number of images found become valid. These outputs hold until the end of the next scan.

Top module: `boot_image_picker`

## Requirements
- R1: The first header is read at `BASE_ADDR`. The factory image found there is always counted, even when its tag word reads all ones.
- R2: A header is two 32-bit words. The tag is at header address H and the byte length L is at H+4. The next header is at H+8+L.
- R3: After the factory image, a tag word of 32'hFFFFFFFF ends the scan. That header is not counted as an image.
- R4: The scan stops after `MAX_IMAGES` images without reading further. `img_count` reports the number of images counted, from 1 to `MAX_IMAGES`.
- R5: With no override, `sel_tag` is the highest unsigned tag among the counted images, and `sel_addr` is that image's header address.
- R6: When two or more images share the highest tag, the one found first in the scan is selected.
- R7: When `ovr_en` is 1 at `start` and `ovr_idx` is less than `img_count`, the image at that index is selected, whatever its tag (index 0 is the factory image).
- R8: When `ovr_en` is 1 at `start` and `ovr_idx` is not less than `img_count`, the factory image is selected and `ovr_miss` is 1. In every other case `ovr_miss` is 0.
- R9: `done` is high for exactly one cycle per scan. The results hold until the next scan ends. A `start` that arrives while a scan is running is ignored.
- R10: `rd_req` stays high with a stable `rd_addr` until `rd_ack` is seen. `rd_data` is taken in the cycle `rd_ack` is high.
- R11: After reset, `rd_req`, `done`, `ovr_miss`, `sel_addr`, `sel_tag` and `img_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (only used when idle) |
| ovr_en | input | 1 | Force selection by index, captured at start |
| ovr_idx | input | IDX_W | Forced image index, captured at start |
| rd_req | output | 1 | Word read request |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_data | input | 32 | Returned word |
| rd_ack | input | 1 | Read completion strobe |
| done | output | 1 | One-cycle end-of-scan pulse |
| sel_addr | output | ADDR_W | Header address of the selected image |
| sel_tag | output | 32 | Version tag of the selected image |
| img_count | output | CNT_W | Number of images found |
| ovr_miss | output | 1 | Override named a missing image |

## Verification
On every cycle, the assertions check the read handshake, the one-cycle width of `done`, the range of `img_count`, and that the factory address is reported on an override miss. The assertions also check that every scan opens at the factory address. The bench scenarios are needed to show which image is picked. These scenarios cover the highest-tag rule, tie breaking, honoured and missed overrides, the all-ones factory tag, the erased-header stop and the image-count limit. They also show that a mid-scan `start` does not disturb the result. A flash model in the bench flags any read outside the header chain.

// File: rtl/boot_image_picker.sv
module boot_image_picker #(
  parameter int ADDR_W     = 24,
  parameter int BASE_ADDR  = 'h10000,
  parameter int MAX_IMAGES = 8,
  localparam int CNT_W = $clog2(MAX_IMAGES + 1),
  localparam int IDX_W = $clog2(MAX_IMAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ovr_en,
  input  logic [IDX_W-1:0]  ovr_idx,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [31:0]       rd_data,
  input  logic              rd_ack,
  output logic              done,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [31:0]       sel_tag,
  output logic [CNT_W-1:0]  img_count,
  output logic              ovr_miss
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  typedef enum logic [1:0] {IDLE, RD_TAG, RD_SIZE} st_t;
  st_t st;

  logic [ADDR_W-1:0] hdr, best_addr, hit_addr;
  logic [31:0]       cur_tag, best_tag, hit_tag, fac_tag;
  logic [CNT_W-1:0]  cnt;
  logic              hit, oen_q;
  logic [IDX_W-1:0]  oidx_q;

  wire size_ack = (st == RD_SIZE) && rd_ack;
  wire take     = (cnt == '0) || (cur_tag > best_tag);
  wire hit_now  = oen_q && (CNT_W'(oidx_q) == cnt);
  wire erased   = (rd_data == 32'hFFFF_FFFF) && (cnt != '0);

  wire [CNT_W-1:0]  n_cnt       = size_ack ? cnt + 1'b1 : cnt;
  wire [31:0]       n_best_tag  = (size_ack && take) ? cur_tag : best_tag;
  wire [ADDR_W-1:0] n_best_addr = (size_ack && take) ? hdr : best_addr;
  wire [31:0]       n_fac_tag   = (size_ack && cnt == '0) ? cur_tag : fac_tag;
  wire              n_hit       = hit || (size_ack && hit_now);
  wire [31:0]       n_hit_tag   = (size_ack && hit_now) ? cur_tag : hit_tag;
  wire [ADDR_W-1:0] n_hit_addr  = (size_ack && hit_now) ? hdr : hit_addr;

  wire finish = ((st == RD_TAG) && rd_ack && erased) ||
                (size_ack && n_cnt == CNT_W'(MAX_IMAGES));

  assign rd_req  = (st != IDLE);
  assign rd_addr = (st == RD_SIZE) ? hdr + ADDR_W'(4) : hdr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; hdr <= '0; cur_tag <= '0; cnt <= '0;
      best_tag <= '0; best_addr <= '0; fac_tag <= '0;
      hit <= 1'b0; hit_tag <= '0; hit_addr <= '0;
      oen_q <= 1'b0; oidx_q <= '0;
      done <= 1'b0; sel_addr <= '0; sel_tag <= '0; img_count <= '0; ovr_miss <= 1'b0;
    end else begin
      done      <= finish;
      cnt       <= n_cnt;
      best_tag  <= n_best_tag;
      best_addr <= n_best_addr;
      fac_tag   <= n_fac_tag;
      hit       <= n_hit;
      hit_tag   <= n_hit_tag;
      hit_addr  <= n_hit_addr;
      case (st)
        IDLE: if (start) begin
          hdr <= BASE; cnt <= '0; hit <= 1'b0;
          oen_q <= ovr_en; oidx_q <= ovr_idx;
          st <= RD_TAG;
        end
        RD_TAG: if (rd_ack) begin
          if (erased) st <= IDLE;
          else begin
            cur_tag <= rd_data;
            st <= RD_SIZE;
          end
        end
        RD_SIZE: if (rd_ack) begin
          hdr <= hdr + ADDR_W'(8) + rd_data[ADDR_W-1:0];
          st  <= finish ? IDLE : RD_TAG;
        end
        default: st <= IDLE;
      endcase
      if (finish) begin
        img_count <= n_cnt;
        ovr_miss  <= oen_q && !n_hit;
        sel_addr  <= oen_q ? (n_hit ? n_hit_addr : BASE) : n_best_addr;
        sel_tag   <= oen_q ? (n_hit ? n_hit_tag : n_fac_tag) : n_best_tag;
      end
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_count_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> img_count >= CNT_W'(1) && img_count <= CNT_W'(MAX_IMAGES));
  p_miss_factory_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && ovr_miss |-> sel_addr == BASE);
  p_first_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> rd_addr == BASE);
endmodule

// File: tb/boot_image_picker_bench.sv
module boot_image_picker_bench;
  localparam int AW = 24, BASE = 'h10000, MAXI = 8, CW = 4, IW = 3;

  logic clk = 0, rst_n = 0, start = 0, ovr_en = 0, rd_ack = 0;
  logic [IW-1:0] ovr_idx = '0;
  logic [31:0] rd_data = '0;
  logic rd_req, done, ovr_miss;
  logic [AW-1:0] rd_addr, sel_addr;
  logic [31:0] sel_tag;
  logic [CW-1:0] img_count;

  int total = 0, bad = 0, stray = 0, cycles = 0;
  logic [31:0] tg [0:15];
  logic [31:0] sz [0:15];
  logic [AW-1:0] ha [0:16];
  int nimg = 1;

  always #4 clk = ~clk;

  boot_image_picker #(.ADDR_W(AW), .BASE_ADDR(BASE), .MAX_IMAGES(MAXI)) u_boot_image_picker (
    .clk(clk), .rst_n(rst_n), .start(start), .ovr_en(ovr_en), .ovr_idx(ovr_idx),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ack(rd_ack),
    .done(done), .sel_addr(sel_addr), .sel_tag(sel_tag), .img_count(img_count),
    .ovr_miss(ovr_miss));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lookup(logic [AW-1:0] a);
    int lim = (nimg < MAXI) ? nimg : MAXI;
    for (int i = 0; i < nimg; i++) begin
      if (a == ha[i]) return tg[i];
      if (a == ha[i] + AW'(4)) return sz[i];
    end
    if (!(lim < MAXI && a == ha[lim])) stray++;
    return 32'hFFFF_FFFF;
  endfunction

  initial begin : responder
    int lat = 0;
    forever begin
      @(negedge clk);
      if (rd_ack) rd_ack = 0;
      else if (rd_req) begin
        if (lat == 0) begin
          rd_data = lookup(rd_addr);
          rd_ack = 1;
          lat = $urandom_range(0, 3);
        end else lat--;
      end
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  function automatic void layout();
    ha[0] = AW'(BASE);
    for (int i = 1; i <= nimg; i++) ha[i] = ha[i-1] + AW'(8) + sz[i-1][AW-1:0];
  endfunction

  task automatic run(string tag, bit oen, int oidx, bit busy_start);
    int cnt, sel, waitc, extra;
    bit miss;
    layout();
    cnt = (nimg < MAXI) ? nimg : MAXI;
    sel = 0;
    for (int i = 1; i < cnt; i++) if (tg[i] > tg[sel]) sel = i;
    miss = 0;
    if (oen) begin
      if (oidx < cnt) sel = oidx;
      else begin sel = 0; miss = 1; end
    end
    stray = 0;
    @(negedge clk);
    start = 1; ovr_en = oen; ovr_idx = IW'(oidx);
    @(negedge clk);
    start = 0; ovr_en = 0; ovr_idx = '0;
    if (busy_start) begin
      repeat (4) @(negedge clk);
      start = 1; ovr_en = 1; ovr_idx = '1;
      @(negedge clk);
      start = 0; ovr_en = 0; ovr_idx = '0;
    end
    waitc = 0;
    while (!done && waitc < 3000) begin @(negedge clk); waitc++; end
    chk({tag, " R9 done seen"}, 32'(done), 32'd1);
    chk({tag, " R4 img_count"}, 32'(img_count), 32'(cnt));
    chk({tag, " R5/R6/R7 sel_addr"}, 32'(sel_addr), 32'(ha[sel]));
    chk({tag, " R5/R6/R7 sel_tag"}, sel_tag, tg[sel]);
    chk({tag, " R8 ovr_miss"}, 32'(ovr_miss), 32'(miss));
    chk({tag, " R2/R3 stray reads"}, 32'(stray), 32'd0);
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, 32'(done), 32'd0);
    extra = 0;
    repeat (20) begin @(negedge clk); if (done) extra++; end
    chk({tag, " R9 single pulse"}, 32'(extra), 32'd0);
    chk({tag, " R9 result held"}, 32'(sel_addr), 32'(ha[sel]));
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk("R11 rd_req", 32'(rd_req), 0);
    chk("R11 done", 32'(done), 0);
    chk("R11 sel_addr", 32'(sel_addr), 0);
    chk("R11 img_count", 32'(img_count), 0);
    chk("R11 ovr_miss", 32'(ovr_miss), 0);
    rst_n = 1;

    // R1: factory only; then factory tag all ones
    nimg = 1; tg[0] = 32'h5; sz[0] = 32'h40;
    run("factory only", 0, 0, 0);
    nimg = 2; tg[0] = 32'hFFFF_FFFF; sz[0] = 32'h10; tg[1] = 32'h9; sz[1] = 32'h20;
    run("R1 erased-looking factory", 0, 0, 0);
    // R6: tie, earliest wins
    nimg = 4; tg[0] = 1; tg[1] = 7; tg[2] = 3; tg[3] = 7;
    for (int i = 0; i < 4; i++) sz[i] = 32'(4 * (i + 3));
    run("R6 tie", 0, 0, 0);
    // R7 valid override to a low tag
    run("R7 override", 1, 2, 0);
    // R8 override miss
    run("R8 override miss", 1, 5, 0);
    // R4 limit with more images than MAX
    nimg = 11;
    for (int i = 0; i < 11; i++) begin tg[i] = 32'(i); sz[i] = 32'h8; end
    run("R4 limit", 0, 0, 0);
    // R9 start while busy
    nimg = 6;
    for (int i = 0; i < 6; i++) begin tg[i] = 32'(10 - i); sz[i] = 32'h20; end
    run("R9 busy start", 0, 0, 1);

    for (int k = 0; k < 40; k++) begin
      nimg = $urandom_range(1, 10);
      for (int i = 0; i < nimg; i++) begin
        tg[i] = $urandom_range(0, 7);
        sz[i] = 32'(4 * $urandom_range(0, 64));
      end
      run("random R5", ($urandom_range(0, 2) == 0), $urandom_range(0, 7), 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule